// File: doc/BRIEF.md
# Filter Mode Output Mixer

This block is the last stage of a voice-synthesis audio path. Each sample cycle it receives the sum of the voices that bypass the filter (the dry sum) together with the three state values of a two-integrator filter core: highpass, bandpass and lowpass. A 3-bit mode field chooses which of the three filter taps are folded into the mix. A signed DC offset is added, and the total is scaled by a 4-bit master volume.

A filter-enable input selects between the normal mix and a bypass path in which only the dry sum and the offset reach the volume stage. Mode, volume, enable and offset are plain inputs sampled with each valid sample; no register decoding happens here. The result is registered, appears one cycle after its input sample with a matching valid strobe, and is kept at full precision with no saturation.

Top module: `mixmode_out_stage`

## Requirements
- R1: Mode bit 0 adds the lowpass tap, bit 1 adds the bandpass tap and bit 2 adds the highpass tap; any combination of the three bits may be set at once.
- R2: With mode equal to 0 no filter tap reaches the output, however large the tap values are.
- R3: Every selected tap enters the sum with a weight of exactly one, with no scaling, averaging or normalisation.
- R4: With filtering enabled, mix_out equals (dry_sum + selected taps + dc_offset) × volume, where all sample inputs are signed two's complement and volume is unsigned (0 to 15).
- R5: With filt_en low, mix_out equals (dry_sum + dc_offset) × volume and the tap inputs and mode field have no effect.
- R6: A volume of 0 gives mix_out equal to 0 whatever the other inputs hold.
- R7: An input sample presented with in_valid high appears on mix_out one clock later, and out_valid is in_valid delayed by exactly one clock.
- R8: In a cycle where in_valid is low, mix_out keeps its previous value.
- R9: While reset is asserted, and after it until the first valid sample, out_valid is 0 and mix_out is 0.
- R10: The output is exact over the full input range: five full-scale negative or positive inputs at volume 15 produce the true product without wrapping or clipping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample strobe; also the clock enable of the output register |
| filt_en | input | 1 | 1: normal mix with filter taps; 0: bypass, taps ignored |
| mode | input | 3 | Tap select: bit 0 lowpass, bit 1 bandpass, bit 2 highpass |
| volume | input | 4 | Unsigned master volume 0..15 |
| dry_sum | input | SAMPLE_W | Signed sum of voices that bypass the filter |
| hp_tap | input | SAMPLE_W | Signed highpass state |
| bp_tap | input | SAMPLE_W | Signed bandpass state |
| lp_tap | input | SAMPLE_W | Signed lowpass state |
| dc_offset | input | SAMPLE_W | Signed mixer DC offset |
| out_valid | output | 1 | Output strobe, in_valid delayed one clock |
| mix_out | output | SAMPLE_W+3+VOL_W | Signed full-precision scaled mix |

## Verification
The bench walks each single mode bit with distinct tap values so that a swapped bit-to-tap mapping shows up as the wrong tap's value, and runs all multi-bit modes so that a design averaging or shifting the taps gives a scaled result. It drives large taps with mode 0 and with the filter disabled, where a design leaking a tap would add it to the output. Volume 0 with busy inputs catches a volume treated as signed or offset by one, and full-scale extremes at volume 15 catch a sum or product one bit too narrow, which would wrap to the opposite sign. Gaps in in_valid catch an output register that updates without an enable or a valid strobe on the wrong cycle.

// File: rtl/mixmode_pkg.sv
`timescale 1ns/1ps
package mixmode_pkg;

  // Position of each filter tap inside the packed tap vector; this order is
  // also the order of the mode bits that select them.
  typedef enum logic [1:0] {
    TAP_LP = 2'd0,
    TAP_BP = 2'd1,
    TAP_HP = 2'd2
  } tap_idx_e;

  localparam int NUM_TAPS = 3;

  // Growth of the sum over the tap width: three taps need two bits,
  // three taps plus dry plus offset (five terms) need three.
  localparam int WET_GROWTH = 2;
  localparam int MIX_GROWTH = 3;

endpackage

// File: rtl/mixmode_tap_select.sv
`timescale 1ns/1ps
module mixmode_tap_select
  import mixmode_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  localparam int WET_W = SAMPLE_W + WET_GROWTH
) (
  input  logic                               filt_en,
  input  logic [NUM_TAPS-1:0]                tap_sel,
  input  logic [NUM_TAPS-1:0][SAMPLE_W-1:0]  taps,
  output logic signed [WET_W-1:0]            wet_sum
);

  logic signed [WET_W-1:0] gated [NUM_TAPS];

  // One gate per tap; the bypass path forces every gate closed.
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_gate
    logic signed [SAMPLE_W-1:0] tap_s;
    logic                       pass;

    always_comb begin
      tap_s = $signed(taps[g]);
      pass  = filt_en & tap_sel[g];
    end

    always_comb begin
      if (pass) begin
        gated[g] = WET_W'(tap_s);
      end else begin
        gated[g] = '0;
      end
    end
  end

  // Unweighted sum of the open gates.
  always_comb begin
    wet_sum = '0;
    for (int k = 0; k < NUM_TAPS; k++) begin
      wet_sum = wet_sum + gated[k];
    end
  end

endmodule

// File: rtl/mixmode_sum.sv
`timescale 1ns/1ps
module mixmode_sum
  import mixmode_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  localparam int WET_W = SAMPLE_W + WET_GROWTH,
  localparam int SUM_W = SAMPLE_W + MIX_GROWTH
) (
  input  logic signed [SAMPLE_W-1:0] dry_sum,
  input  logic signed [WET_W-1:0]    wet_sum,
  input  logic signed [SAMPLE_W-1:0] dc_offset,
  output logic signed [SUM_W-1:0]    mix_sum
);

  logic signed [SUM_W-1:0] dry_ext;
  logic signed [SUM_W-1:0] wet_ext;
  logic signed [SUM_W-1:0] off_ext;

  always_comb begin
    dry_ext = SUM_W'(dry_sum);
    wet_ext = SUM_W'(wet_sum);
    off_ext = SUM_W'(dc_offset);
    mix_sum = dry_ext + wet_ext + off_ext;
  end

endmodule

// File: rtl/mixmode_vol_scale.sv
`timescale 1ns/1ps
module mixmode_vol_scale #(
  parameter int SUM_W = 19,
  parameter int VOL_W = 4,
  localparam int PROD_W = SUM_W + VOL_W
) (
  input  logic signed [SUM_W-1:0]  mix_sum,
  input  logic        [VOL_W-1:0]  volume,
  output logic signed [PROD_W-1:0] scaled
);

  // The volume is unsigned: widen it with a zero sign bit before the
  // signed multiply so that 8..15 never read as negative.
  logic signed [PROD_W-1:0] sum_ext;
  logic signed [PROD_W-1:0] vol_ext;

  always_comb begin
    sum_ext = PROD_W'(mix_sum);
    vol_ext = $signed({{(PROD_W-VOL_W){1'b0}}, volume});
    scaled  = sum_ext * vol_ext;
  end

endmodule

// File: rtl/mixmode_out_stage.sv
`timescale 1ns/1ps
module mixmode_out_stage
  import mixmode_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int VOL_W    = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               in_valid,
  input  logic                               filt_en,
  input  logic [NUM_TAPS-1:0]                mode,
  input  logic [VOL_W-1:0]                   volume,
  input  logic signed [SAMPLE_W-1:0]         dry_sum,
  input  logic signed [SAMPLE_W-1:0]         hp_tap,
  input  logic signed [SAMPLE_W-1:0]         bp_tap,
  input  logic signed [SAMPLE_W-1:0]         lp_tap,
  input  logic signed [SAMPLE_W-1:0]         dc_offset,
  output logic                               out_valid,
  output logic signed [SAMPLE_W+MIX_GROWTH+VOL_W-1:0] mix_out
);

  localparam int WET_W  = SAMPLE_W + WET_GROWTH;
  localparam int SUM_W  = SAMPLE_W + MIX_GROWTH;
  localparam int PROD_W = SUM_W + VOL_W;

  // ---------------------------------------------------------------------
  // Reset: asserted asynchronously, released on the second clock edge.
  // ---------------------------------------------------------------------
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe[1];

  // ---------------------------------------------------------------------
  // Datapath
  // ---------------------------------------------------------------------
  logic [NUM_TAPS-1:0][SAMPLE_W-1:0] taps;
  logic signed [WET_W-1:0]           wet_sum;
  logic signed [SUM_W-1:0]           mix_sum;
  logic signed [PROD_W-1:0]          scaled;

  always_comb begin
    taps               = '0;
    taps[int'(TAP_LP)] = lp_tap;
    taps[int'(TAP_BP)] = bp_tap;
    taps[int'(TAP_HP)] = hp_tap;
  end

  mixmode_tap_select #(
    .SAMPLE_W (SAMPLE_W)
  ) u_sel (
    .filt_en  (filt_en),
    .tap_sel  (mode),
    .taps     (taps),
    .wet_sum  (wet_sum)
  );

  mixmode_sum #(
    .SAMPLE_W (SAMPLE_W)
  ) u_sum (
    .dry_sum   (dry_sum),
    .wet_sum   (wet_sum),
    .dc_offset (dc_offset),
    .mix_sum   (mix_sum)
  );

  mixmode_vol_scale #(
    .SUM_W (SUM_W),
    .VOL_W (VOL_W)
  ) u_vol (
    .mix_sum (mix_sum),
    .volume  (volume),
    .scaled  (scaled)
  );

  // ---------------------------------------------------------------------
  // Output register: next state, then register, in_valid as clock enable.
  // ---------------------------------------------------------------------
  logic                     out_en;
  logic                     valid_d;
  logic signed [PROD_W-1:0] mix_d;

  always_comb begin
    out_en  = in_valid;
    valid_d = in_valid;
    mix_d   = mix_out;
    if (out_en) begin
      mix_d = scaled;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      mix_out   <= '0;
    end else begin
      out_valid <= valid_d;
      mix_out   <= mix_d;
    end
  end

endmodule

// File: rtl/mixmode_out_stage_chk.sv
`timescale 1ns/1ps
module mixmode_out_stage_chk #(
  parameter int WET_W = 18,
  parameter int OUT_W = 23,
  parameter int VOL_W = 4,
  parameter int MODE_W = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    filt_en,
  input logic [MODE_W-1:0]       mode,
  input logic [VOL_W-1:0]        volume,
  input logic signed [WET_W-1:0] wet_sum,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] mix_out
);

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);                                          // R7

  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);                                        // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(mix_out));                                  // R8

  AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && volume == '0) |=> (mix_out == '0));                  // R6

  AST_BYPASS_NO_TAPS: assert property (@(posedge clk) disable iff (!rst_n)
    !filt_en |-> (wet_sum == '0));                                    // R5

  AST_MODE_OFF_NO_TAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == '0) |-> (wet_sum == '0));                                // R2

endmodule

bind mixmode_out_stage mixmode_out_stage_chk #(
  .WET_W  (SAMPLE_W + mixmode_pkg::WET_GROWTH),
  .OUT_W  (SAMPLE_W + mixmode_pkg::MIX_GROWTH + VOL_W),
  .VOL_W  (VOL_W),
  .MODE_W (mixmode_pkg::NUM_TAPS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .filt_en   (filt_en),
  .mode      (mode),
  .volume    (volume),
  .wet_sum   (wet_sum),
  .out_valid (out_valid),
  .mix_out   (mix_out)
);

// File: tb/mixmode_out_stage_tb.sv
`timescale 1ns/1ps
module mixmode_out_stage_tb;

  localparam int SW = 16;
  localparam int VW = 4;
  localparam int OW = SW + 3 + VW;

  logic                 clk;
  logic                 rst_n;
  logic                 in_valid;
  logic                 filt_en;
  logic [2:0]           mode;
  logic [VW-1:0]        volume;
  logic signed [SW-1:0] dry_sum, hp_tap, bp_tap, lp_tap, dc_offset;
  logic                 out_valid;
  logic signed [OW-1:0] mix_out;

  int    total;
  int    bad;
  string cur_req;

  mixmode_out_stage #(.SAMPLE_W(SW), .VOL_W(VW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .filt_en   (filt_en),
    .mode      (mode),
    .volume    (volume),
    .dry_sum   (dry_sum),
    .hp_tap    (hp_tap),
    .bp_tap    (bp_tap),
    .lp_tap    (lp_tap),
    .dc_offset (dc_offset),
    .out_valid (out_valid),
    .mix_out   (mix_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural reference: arithmetic on 64-bit integers from the requirements.
  function automatic longint ref_mix(bit en, bit [2:0] md, int vol,
                                     longint dry, longint hp, longint bp,
                                     longint lp, longint off);
    longint wet;
    wet = 0;
    if (en) begin
      if (md[0]) wet += lp;   // R1 bit 0 lowpass
      if (md[1]) wet += bp;   // R1 bit 1 bandpass
      if (md[2]) wet += hp;   // R1 bit 2 highpass
    end
    return (dry + wet + off) * longint'(vol);
  endfunction

  longint exp_out;
  bit     exp_valid;
  string  exp_tag;
  bit     cmp_on;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_out   = 0;
      exp_valid = 1'b0;
      exp_tag   = "R9";
    end else begin
      exp_valid = in_valid;
      exp_tag   = cur_req;
      if (in_valid) begin
        exp_out = ref_mix(filt_en, mode, int'(volume),
                          longint'(dry_sum), longint'(hp_tap), longint'(bp_tap),
                          longint'(lp_tap), longint'(dc_offset));
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      total++;
      if (out_valid !== exp_valid) begin
        bad++;
        $display("FAIL R7 (%s) out_valid actual=%0b expected=%0b", exp_tag, out_valid, exp_valid);
      end
      total++;
      if (longint'(mix_out) !== exp_out) begin
        bad++;
        $display("FAIL %s mix_out actual=%0d expected=%0d", exp_tag, longint'(mix_out), exp_out);
      end
    end
  end

  task automatic drive(bit v, bit en, bit [2:0] md, int vol,
                       int dry, int hp, int bp, int lp, int off);
    @(negedge clk);
    in_valid  = v;
    filt_en   = en;
    mode      = md;
    volume    = VW'(vol);
    dry_sum   = SW'(dry);
    hp_tap    = SW'(hp);
    bp_tap    = SW'(bp);
    lp_tap    = SW'(lp);
    dc_offset = SW'(off);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b1, 3'd0, 1, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0; cmp_on = 1'b0; cur_req = "R9";
    rst_n = 1'b0; in_valid = 1'b0; filt_en = 1'b1; mode = '0; volume = '0;
    dry_sum = '0; hp_tap = '0; bp_tap = '0; lp_tap = '0; dc_offset = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    total++;
    if (out_valid !== 1'b0 || mix_out !== '0) begin
      bad++;
      $display("FAIL R9 reset actual=%0b/%0d expected=0/0", out_valid, mix_out);
    end
    rst_n = 1'b1;
    idle(4);
    total++;
    if (out_valid !== 1'b0 || mix_out !== '0) begin
      bad++;
      $display("FAIL R9 after release actual=%0b/%0d expected=0/0", out_valid, mix_out);
    end
    cmp_on = 1'b1;

    // R1: each mode bit alone, distinct tap values
    cur_req = "R1";
    drive(1, 1, 3'b001, 1, 10, 3000, 200, 7, 0);
    drive(1, 1, 3'b010, 1, 10, 3000, 200, 7, 0);
    drive(1, 1, 3'b100, 1, 10, 3000, 200, 7, 0);
    // R3: combinations summed with unit weight
    cur_req = "R3";
    for (int m = 3; m < 8; m++) drive(1, 1, 3'(m), 1, -5, 1001, -2002, 4004, 0);
    drive(1, 1, 3'b111, 3, 0, 32767, 32767, 32767, 0);
    // R2: mode 0 with large taps
    cur_req = "R2";
    drive(1, 1, 3'b000, 7, 123, 32000, -32000, 31000, -9);
    drive(1, 1, 3'b000, 15, -1, -32768, -32768, -32768, 0);
    // R4: general mix, including negative offset and volumes above 7
    cur_req = "R4";
    for (int i = 0; i < 200; i++)
      drive(1, 1, 3'($urandom), int'($urandom % 16), int'($urandom), int'($urandom),
            int'($urandom), int'($urandom), int'($urandom));
    drive(1, 1, 3'b011, 9, 100, 0, 50, 25, -400);
    // R5: bypass ignores taps and mode
    cur_req = "R5";
    for (int m = 0; m < 8; m++) drive(1, 0, 3'(m), 5, 777, 30000, -30000, 12345, -77);
    for (int i = 0; i < 50; i++)
      drive(1, 0, 3'($urandom), int'($urandom % 16), int'($urandom), int'($urandom),
            int'($urandom), int'($urandom), int'($urandom));
    // R6: volume zero
    cur_req = "R6";
    drive(1, 1, 3'b111, 0, 32767, 32767, 32767, 32767, 32767);
    drive(1, 0, 3'b101, 0, -32768, 1, 2, 3, -32768);
    // R8 / R7: gaps in valid while inputs keep moving
    cur_req = "R8";
    drive(1, 1, 3'b110, 11, 4321, -1234, 999, 0, 55);
    for (int i = 0; i < 60; i++)
      drive(bit'($urandom % 2), bit'($urandom % 2), 3'($urandom), int'($urandom % 16),
            int'($urandom), int'($urandom), int'($urandom), int'($urandom), int'($urandom));
    // R10: full-scale extremes at maximum volume
    cur_req = "R10";
    drive(1, 1, 3'b111, 15, -32768, -32768, -32768, -32768, -32768);
    drive(1, 1, 3'b111, 15, 32767, 32767, 32767, 32767, 32767);
    drive(1, 0, 3'b111, 15, -32768, 5, 5, 5, -32768);
    cur_req = "R7";
    idle(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule